// File: doc/BRIEF.md
# Dual-Master Ownership Semaphore

This block decides which of two processor cores drives one shared resource, for example a charge pump or a set of clock-setup registers. Each core has its own register port with an address, a write strobe, a 32-bit write bus and a read bus. A 2-bit ownership state sits in the low two bits of the semaphore register. The primary core claims with one code and the secondary core claims with another. Only the current owner can release. If both cores claim in the same cycle, the primary core wins.

After reset the state is free. In that state the resource is routed to the primary core, but no lock is held. The block drives a registered owner-select output and a locked flag. It also holds a small bank of protected configuration registers. The primary core may write these registers unless the secondary core holds the semaphore. The secondary core may write them only while it holds the semaphore. A write that is refused is dropped and sets a sticky per-port violation flag.

Top module: `dual_own_sem`

## Requirements
- R1: After reset the state reads 00, `owner_sec` and `locked` are 0, both violation flags are 0 and every protected register is 0.
- R2: Writing code 10 to the semaphore register (address 0, bits [1:0]) from the primary port while the state is 00 makes the state 10, with `locked` set.
- R3: Writing code 01 from the secondary port while the state is 00 makes the state 01, with `locked` set and `owner_sec` set.
- R4: Writing 00 returns the state to 00 only when it comes from the port that owns the state. A release write from the other port is ignored.
- R5: Some writes leave the state unchanged: a claim from the non-owning port while locked, the code 11, and the other port's claim code. The state never moves directly between 10 and 01.
- R6: If both ports write their claim codes in the same cycle while the state is 00, the state becomes 10.
- R7: A read of address 0 from either port returns the current state in bits [1:0], with zeros in all upper bits. Upper write-data bits are ignored when the code is decoded.
- R8: `owner_sec` and `locked` are registered. They change on the clock edge that accepts the write and do not follow the write strobe combinationally.
- R9: Protected registers sit at addresses 8 and up, one per register. The primary port has write access (`cfg_wen_pri`) whenever the state is not 01. The secondary port has write access (`cfg_wen_sec`) only while the state is 01. A granted write stores the data, and the register reads back zero-extended.
- R10: A write to a protected register without access leaves the register unchanged and sets that port's violation flag. The flag reads back at address 1, bit 0. Writing 1 to bit 0 clears it, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_wr | input | 1 | Primary port write strobe |
| pri_addr | input | ADDR_W | Primary port register address |
| pri_wdata | input | DATA_W | Primary port write data |
| pri_rdata | output | DATA_W | Primary port read data for `pri_addr` |
| sec_wr | input | 1 | Secondary port write strobe |
| sec_addr | input | ADDR_W | Secondary port register address |
| sec_wdata | input | DATA_W | Secondary port write data |
| sec_rdata | output | DATA_W | Secondary port read data for `sec_addr` |
| owner_sec | output | 1 | Resource routed to the secondary core |
| locked | output | 1 | Semaphore held by a core |
| cfg_wen_pri | output | 1 | Primary port may write protected registers |
| cfg_wen_sec | output | 1 | Secondary port may write protected registers |
| pri_viol | output | 1 | Sticky refused-write flag, primary port |
| sec_viol | output | 1 | Sticky refused-write flag, secondary port |
| cfg_flat | output | NUM_CFG*CFG_W | Protected register contents, register 0 in the low bits |

## Verification
The bench builds the block with three protected registers of 16 bits each, behind 32-bit ports and 4-bit addresses. With these values the bank size is not a power of two, so an address just past the last register must hit nothing. Each register is also narrower than the bus, so the zero-extended readback and the dropped upper write bits can both be seen at the ports. A table of paired port writes walks every legal and illegal transition of the state, including same-cycle claim and release races. Directed tests then cover the registered owner timing, the access gating, and the sticky flags.

// File: rtl/osem_pkg.sv
// Shared encodings for the dual-master ownership semaphore.
// Assumes the state field is exactly two bits wide.
package osem_pkg;

    typedef enum logic [1:0] {
        SEM_FREE = 2'b00,
        SEM_SEC  = 2'b01,
        SEM_PRI  = 2'b10
    } sem_state_t;

    localparam logic [1:0] CODE_REL = 2'b00;
    localparam logic [1:0] CODE_SEC = 2'b01;
    localparam logic [1:0] CODE_PRI = 2'b10;

    localparam int SEM_ADDR  = 0;
    localparam int VIOL_ADDR = 1;

endpackage

// File: rtl/osem_state.sv
// Ownership state machine. It takes the decoded semaphore writes of both
// ports and keeps the 2-bit state, a registered owner select and a
// registered lock flag.
// Assumes each port offers at most one write per cycle.
module osem_state
    import osem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_wr,
    input  logic [1:0] pri_code,
    input  logic       sec_wr,
    input  logic [1:0] sec_code,
    output sem_state_t state_q,
    output logic       owner_sec_q,
    output logic       locked_q
);

    sem_state_t state_d;

    logic pri_claim, sec_claim, pri_rel, sec_rel;

    // Qualify each port's write by its own entitled codes.
    always_comb begin
        pri_claim = pri_wr && (pri_code == CODE_PRI);
        sec_claim = sec_wr && (sec_code == CODE_SEC);
        pri_rel   = pri_wr && (pri_code == CODE_REL);
        sec_rel   = sec_wr && (sec_code == CODE_REL);
    end

    // Next state: the primary port has priority when free, and only the owner may release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (pri_claim)      state_d = SEM_PRI;
                else if (sec_claim) state_d = SEM_SEC;
            end
            SEM_PRI: if (pri_rel) state_d = SEM_FREE;
            SEM_SEC: if (sec_rel) state_d = SEM_FREE;
            default: state_d = SEM_FREE;
        endcase
    end

    // Register the state and the outputs derived from it, so that nothing glitches between masters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEM_FREE;
            owner_sec_q <= 1'b0;
            locked_q    <= 1'b0;
        end else begin
            state_q     <= state_d;
            owner_sec_q <= (state_d == SEM_SEC);
            locked_q    <= (state_d != SEM_FREE);
        end
    end

    assert_pri_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && pri_claim) |=> (state_q == SEM_PRI));

    assert_sec_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && sec_claim && !pri_claim) |=> (state_q == SEM_SEC));

    assert_owner_only_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_SEC && !sec_rel) |=> (state_q == SEM_SEC));

    assert_no_direct_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_PRI) |=> (state_q != SEM_SEC));

    assert_pri_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && pri_claim && sec_claim) |=> (state_q == SEM_PRI));

    assert_owner_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_sec_q) |-> $past(sec_claim));

endmodule

// File: rtl/osem_port_dec.sv
// Address decoder for one master port. It splits a write into a semaphore
// code, a protected-register write (gated by the port's access right) and
// a violation-flag clear. It also holds the port's sticky violation flag.
// Assumes NUM_CFG registers fit in the upper half of the address space.
module osem_port_dec
    import osem_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int NUM_CFG = 4,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_access,
    output logic              sem_wr,
    output logic [1:0]        sem_code,
    output logic              hit_sem,
    output logic              hit_viol,
    output logic              hit_cfg,
    output logic [IDX_W-1:0]  cfg_idx,
    output logic              cfg_wr_ok,
    output logic              viol_q
);

    localparam int            CFG_BASE = 2 ** (ADDR_W - 1);
    localparam logic [ADDR_W:0] CFG_LO = (ADDR_W + 1)'(CFG_BASE);
    localparam logic [ADDR_W:0] CFG_HI = (ADDR_W + 1)'(CFG_BASE + NUM_CFG);

    logic [ADDR_W-1:0] cfg_off;
    logic              cfg_denied;
    logic              viol_clr;

    // Decode the address window and the register index inside the bank.
    always_comb begin
        hit_sem    = (addr == ADDR_W'(SEM_ADDR));
        hit_viol   = (addr == ADDR_W'(VIOL_ADDR));
        hit_cfg    = ({1'b0, addr} >= CFG_LO) && ({1'b0, addr} < CFG_HI);
        cfg_off    = addr - ADDR_W'(CFG_BASE);
        cfg_idx    = cfg_off[IDX_W-1:0];
        sem_wr     = wr && hit_sem;
        sem_code   = wdata[1:0];
        cfg_wr_ok  = wr && hit_cfg && cfg_access;
        cfg_denied = wr && hit_cfg && !cfg_access;
        viol_clr   = wr && hit_viol && wdata[0];
    end

    // Sticky flag: set by a refused protected write, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)          viol_q <= 1'b0;
        else if (cfg_denied) viol_q <= 1'b1;
        else if (viol_clr)   viol_q <= 1'b0;
    end

    assert_viol_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_denied |=> viol_q);

    assert_viol_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_viol && wdata[0]) |=> !viol_q);

endmodule

// File: rtl/osem_cfg_bank.sv
// Bank of protected configuration registers. It accepts only the writes
// that the port decoders have already granted.
// Assumes the two grants are never active together, so the primary
// port is served first only as a safeguard.
module osem_cfg_bank #(
    parameter int NUM_CFG = 4,
    parameter int CFG_W   = 32,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pri_wr_ok,
    input  logic [IDX_W-1:0]         pri_idx,
    input  logic [CFG_W-1:0]         pri_data,
    input  logic                     sec_wr_ok,
    input  logic [IDX_W-1:0]         sec_idx,
    input  logic [CFG_W-1:0]         sec_data,
    output logic [NUM_CFG*CFG_W-1:0] cfg_flat
);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
        logic [CFG_W-1:0] val_q;

        // Hold one register and load it from whichever port is granted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (pri_wr_ok && pri_idx == IDX_W'(g))
                val_q <= pri_data;
            else if (sec_wr_ok && sec_idx == IDX_W'(g))
                val_q <= sec_data;
        end

        assign cfg_flat[g*CFG_W +: CFG_W] = val_q;
    end

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_wr_ok && sec_wr_ok));

    assert_hold_without_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_wr_ok && !sec_wr_ok) |=> $stable(cfg_flat));

endmodule

// File: rtl/dual_own_sem.sv
// Top level of the dual-master ownership semaphore. It joins two port
// decoders, the ownership state machine and the protected register bank,
// and builds the read data of each port.
// Assumes CFG_W <= DATA_W and NUM_CFG <= 2**(ADDR_W-1).
module dual_own_sem
    import osem_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int NUM_CFG = 4,
    parameter int CFG_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pri_wr,
    input  logic [ADDR_W-1:0]        pri_addr,
    input  logic [DATA_W-1:0]        pri_wdata,
    output logic [DATA_W-1:0]        pri_rdata,
    input  logic                     sec_wr,
    input  logic [ADDR_W-1:0]        sec_addr,
    input  logic [DATA_W-1:0]        sec_wdata,
    output logic [DATA_W-1:0]        sec_rdata,
    output logic                     owner_sec,
    output logic                     locked,
    output logic                     cfg_wen_pri,
    output logic                     cfg_wen_sec,
    output logic                     pri_viol,
    output logic                     sec_viol,
    output logic [NUM_CFG*CFG_W-1:0] cfg_flat
);

    localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

    sem_state_t       state_q;
    logic             p_sem_wr, s_sem_wr;
    logic [1:0]       p_code, s_code;
    logic             p_hsem, s_hsem, p_hviol, s_hviol, p_hcfg, s_hcfg;
    logic [IDX_W-1:0] p_idx, s_idx;
    logic             p_cfg_ok, s_cfg_ok;

    // Access rights come from the registered state only.
    always_comb begin
        cfg_wen_pri = (state_q != SEM_SEC);
        cfg_wen_sec = (state_q == SEM_SEC);
    end

    osem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_pri_dec (
        .clk(clk), .rst_n(rst_n), .wr(pri_wr), .addr(pri_addr), .wdata(pri_wdata),
        .cfg_access(cfg_wen_pri), .sem_wr(p_sem_wr), .sem_code(p_code),
        .hit_sem(p_hsem), .hit_viol(p_hviol), .hit_cfg(p_hcfg), .cfg_idx(p_idx),
        .cfg_wr_ok(p_cfg_ok), .viol_q(pri_viol)
    );

    osem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_sec_dec (
        .clk(clk), .rst_n(rst_n), .wr(sec_wr), .addr(sec_addr), .wdata(sec_wdata),
        .cfg_access(cfg_wen_sec), .sem_wr(s_sem_wr), .sem_code(s_code),
        .hit_sem(s_hsem), .hit_viol(s_hviol), .hit_cfg(s_hcfg), .cfg_idx(s_idx),
        .cfg_wr_ok(s_cfg_ok), .viol_q(sec_viol)
    );

    osem_state u_state (
        .clk(clk), .rst_n(rst_n),
        .pri_wr(p_sem_wr), .pri_code(p_code),
        .sec_wr(s_sem_wr), .sec_code(s_code),
        .state_q(state_q), .owner_sec_q(owner_sec), .locked_q(locked)
    );

    osem_cfg_bank #(.NUM_CFG(NUM_CFG), .CFG_W(CFG_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .pri_wr_ok(p_cfg_ok), .pri_idx(p_idx), .pri_data(pri_wdata[CFG_W-1:0]),
        .sec_wr_ok(s_cfg_ok), .sec_idx(s_idx), .sec_data(sec_wdata[CFG_W-1:0]),
        .cfg_flat(cfg_flat)
    );

    // Read mux for one port: state, its own flag, or a zero-extended register.
    function automatic logic [DATA_W-1:0] rd_word(
        input logic hs, input logic hv, input logic hc,
        input logic [IDX_W-1:0] idx, input logic viol
    );
        logic [DATA_W-1:0] w;
        w = '0;
        if (hs)      w[1:0]       = state_q;
        else if (hv) w[0]         = viol;
        else if (hc) w[CFG_W-1:0] = cfg_flat[idx*CFG_W +: CFG_W];
        return w;
    endfunction

    // Read data for both ports.
    always_comb begin
        pri_rdata = rd_word(p_hsem, p_hviol, p_hcfg, p_idx, pri_viol);
        sec_rdata = rd_word(s_hsem, s_hviol, s_hcfg, s_idx, sec_viol);
    end

    assert_same_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_hsem && s_hsem) |-> (pri_rdata == sec_rdata));

    assert_exclusive_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wen_pri != cfg_wen_sec));

endmodule

// File: tb/dual_own_sem_bench.sv
module dual_own_sem_bench;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NC = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pri_wr = 1'b0, sec_wr = 1'b0;
    logic [AW-1:0] pri_addr = '0, sec_addr = '0;
    logic [DW-1:0] pri_wdata = '0, sec_wdata = '0;
    logic [DW-1:0] pri_rdata, sec_rdata;
    logic          owner_sec, locked, cfg_wen_pri, cfg_wen_sec, pri_viol, sec_viol;
    logic [NC*CW-1:0] cfg_flat;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_own_sem #(.ADDR_W(AW), .DATA_W(DW), .NUM_CFG(NC), .CFG_W(CW)) u_dual_own_sem (
        .clk(clk), .rst_n(rst_n),
        .pri_wr(pri_wr), .pri_addr(pri_addr), .pri_wdata(pri_wdata), .pri_rdata(pri_rdata),
        .sec_wr(sec_wr), .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
        .owner_sec(owner_sec), .locked(locked), .cfg_wen_pri(cfg_wen_pri),
        .cfg_wen_sec(cfg_wen_sec), .pri_viol(pri_viol), .sec_viol(sec_viol),
        .cfg_flat(cfg_flat)
    );

    typedef struct packed {
        logic          pw;
        logic [AW-1:0] pa;
        logic [DW-1:0] pd;
        logic          sw;
        logic [AW-1:0] sa;
        logic [DW-1:0] sd;
        logic [1:0]    exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0, 32'h0000_0002, 1'b0, 4'd0, 32'h0, 2'b10}, // R2 primary claim
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h1, 2'b10}, // R5 secondary claim ignored
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h0, 2'b10}, // R4 non-owner release
        '{1'b1, 4'd0, 32'h0000_0001, 1'b0, 4'd0, 32'h0, 2'b10}, // R5 wrong code
        '{1'b1, 4'd0, 32'h0000_0003, 1'b0, 4'd0, 32'h0, 2'b10}, // R5 code 11
        '{1'b1, 4'd0, 32'h0000_0000, 1'b0, 4'd0, 32'h0, 2'b00}, // R4 owner release
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h2, 2'b00}, // R5 secondary with primary code
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h3, 2'b00}, // R5 code 11
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h1, 2'b01}, // R3 secondary claim
        '{1'b1, 4'd0, 32'h0000_0002, 1'b0, 4'd0, 32'h0, 2'b01}, // R5 primary claim ignored
        '{1'b1, 4'd0, 32'h0000_0000, 1'b0, 4'd0, 32'h0, 2'b01}, // R4 non-owner release
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h0, 2'b00}, // R4 owner release
        '{1'b1, 4'd0, 32'h0000_0002, 1'b1, 4'd0, 32'h1, 2'b10}, // R6 both claim
        '{1'b1, 4'd0, 32'h0000_0000, 1'b1, 4'd0, 32'h1, 2'b00}, // R5 release races claim
        '{1'b0, 4'd0, 32'h0,         1'b1, 4'd0, 32'h1, 2'b01}, // R3 claim
        '{1'b1, 4'd0, 32'h0000_0002, 1'b1, 4'd0, 32'h0, 2'b00}, // R5 no direct swap
        '{1'b1, 4'd0, 32'hABCD_0002, 1'b0, 4'd0, 32'h0, 2'b10}, // R7 upper bits ignored
        '{1'b1, 4'd0, 32'hFFFF_FFFC, 1'b0, 4'd0, 32'h0, 2'b00}, // R7 release with upper bits
        '{1'b1, 4'd9, 32'h0000_0002, 1'b1, 4'd1, 32'h1, 2'b00}  // R5 claim codes at other addresses
    };

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with writes on both ports; afterwards the ports idle on address 0.
    task automatic cyc(input logic pw, input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                       input logic sw, input logic [AW-1:0] sa, input logic [DW-1:0] sd);
        @(negedge clk);
        pri_wr = pw; pri_addr = pa; pri_wdata = pd;
        sec_wr = sw; sec_addr = sa; sec_wdata = sd;
        @(posedge clk);
        #2;
        pri_wr = 1'b0; sec_wr = 1'b0; pri_addr = '0; sec_addr = '0;
        #1;
    endtask

    task automatic chk_state(input logic [1:0] e, input string req);
        chk(pri_rdata == {30'd0, e}, req, pri_rdata, {30'd0, e});
        chk(sec_rdata == {30'd0, e}, "R7", sec_rdata, {30'd0, e});
        chk(owner_sec == (e == 2'b01), "R8", {31'd0, owner_sec}, {31'd0, e == 2'b01});
        chk(locked == (e != 2'b00), "R8", {31'd0, locked}, {31'd0, e != 2'b00});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_state(2'b00, "R1");
        chk(!pri_viol && !sec_viol, "R1", {30'd0, pri_viol, sec_viol}, 0);
        chk(cfg_flat == '0, "R1", DW'(cfg_flat[31:0]), 0);

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].pw, VECS[i].pa, VECS[i].pd, VECS[i].sw, VECS[i].sa, VECS[i].sd);
            chk_state(VECS[i].exp, $sformatf("R2-vec%0d", i));
        end

        // R8 owner select does not follow the strobe before the edge
        @(negedge clk);
        sec_wr = 1'b1; sec_wdata = 32'h1;
        #1;
        chk(owner_sec == 1'b0 && locked == 1'b0, "R8", {30'd0, owner_sec, locked}, 0);
        @(posedge clk);
        #2;
        sec_wr = 1'b0;
        chk(owner_sec == 1'b1 && locked == 1'b1, "R8", {30'd0, owner_sec, locked}, 3);

        // R9 secondary holds: only the secondary port may write
        chk(cfg_wen_sec && !cfg_wen_pri, "R9", {30'd0, cfg_wen_pri, cfg_wen_sec}, 1);
        cyc(1'b0, 4'd0, 0, 1'b1, 4'd9, 32'hFFFF_1357);
        sec_addr = 4'd9; #1;
        chk(sec_rdata == 32'h0000_1357, "R9", sec_rdata, 32'h0000_1357);
        cyc(1'b1, 4'd10, 32'h0000_BEEF, 1'b0, 4'd0, 0);
        chk(cfg_flat[2*CW +: CW] == 16'h0, "R10", DW'(cfg_flat[2*CW +: CW]), 0);
        chk(pri_viol == 1'b1 && sec_viol == 1'b0, "R10", {30'd0, pri_viol, sec_viol}, 2);
        cyc(1'b0, 4'd0, 0, 1'b1, 4'd0, 32'h0);
        chk_state(2'b00, "R4");

        // R9 free state: the primary port may write
        chk(cfg_wen_pri && !cfg_wen_sec, "R9", {30'd0, cfg_wen_pri, cfg_wen_sec}, 2);
        cyc(1'b1, 4'd8, 32'h1234_5A5A, 1'b0, 4'd0, 0);
        pri_addr = 4'd8; #1;
        chk(pri_rdata == 32'h0000_5A5A, "R9", pri_rdata, 32'h0000_5A5A);
        pri_addr = 4'd11; #1;
        chk(pri_rdata == 32'h0, "R9", pri_rdata, 0);

        // R10 secondary refused while free; flag readback and clearing
        cyc(1'b0, 4'd0, 0, 1'b1, 4'd8, 32'h0000_7777);
        chk(cfg_flat[0 +: CW] == 16'h5A5A, "R10", DW'(cfg_flat[0 +: CW]), 32'h5A5A);
        sec_addr = 4'd1; #1;
        chk(sec_rdata == 32'h1, "R10", sec_rdata, 1);
        cyc(1'b0, 4'd0, 0, 1'b1, 4'd1, 32'h0000_0000);
        chk(sec_viol == 1'b1, "R10", {31'd0, sec_viol}, 1);
        cyc(1'b0, 4'd0, 0, 1'b1, 4'd1, 32'h0000_0001);
        chk(sec_viol == 1'b0, "R10", {31'd0, sec_viol}, 0);
        cyc(1'b1, 4'd1, 32'h1, 1'b0, 4'd0, 0);
        chk(pri_viol == 1'b0, "R10", {31'd0, pri_viol}, 0);

        // R9 primary still writes while it holds the lock
        cyc(1'b1, 4'd0, 32'h2, 1'b0, 4'd0, 0);
        cyc(1'b1, 4'd10, 32'h0000_C0DE, 1'b0, 4'd0, 0);
        chk(cfg_flat[2*CW +: CW] == 16'hC0DE, "R9", DW'(cfg_flat[2*CW +: CW]), 32'hC0DE);

        // R1 reset mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1; #1;
        chk_state(2'b00, "R1");
        chk(cfg_flat == '0, "R1", DW'(cfg_flat[31:0]), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule